// File: doc/BRIEF.md
# Paired-Converter Scan Sequencer with Limit Interrupts

This block runs a pair of 12-bit converters that sample at the same instant. A pulse on the sync input, normally tied to the start of each PWM period, launches one scan of eight sample slots. The scan is taken as four simultaneous pairs: the first converter fills slots 0 to 3 and the second fills slots 4 to 7. For each slot a programmable channel list chooses which multiplexer input the converter samples.

Every raw code is unsigned. The block subtracts a per-slot offset to form a 13-bit two's-complement result, stores it, and compares it against per-slot upper and lower bounds. A bound violation sets a sticky flag; the flag ANDed with a per-slot enable drives the matching interrupt bit. The analog side is outside the block. It sees a request strobe with two channel numbers and answers later with a valid strobe and two codes.

Software sets the channel list, offsets, bounds and enables through a write port. It fetches results through a slot-indexed read port with one cycle of latency.

Top module: `adc_scan_seq`

## Requirements
- R1: After reset, scan_done, overrun, conv_req and all interrupt outputs are 0, every offset is 0, every upper bound is 4095, every lower bound is -4096, and the channel list for slots 0..7 is 0, 2, 4, 7, 1, 3, 5, 6.
- R2: A scan starts only when sync_in is 1 while the block is idle; conv_req rises in the cycle after that sync, for pair 0.
- R3: Pair p (p = 0..3) carries slot p on conv_ch_a and slot p+4 on conv_ch_b, each driven with that slot's channel. Pairs are requested in the order 0, 1, 2, 3.
- R4: conv_req is high for exactly one cycle per pair. The next pair's request follows in the cycle after the conv_valid that completed the previous pair.
- R5: A write to address s (s = 0..7) loads bits [2:0] into slot s's channel entry.
- R6: On conv_valid the result of slot p is conv_data_a minus the slot's offset, and the result of slot p+4 is conv_data_b minus its offset. Each result is 13-bit two's complement, so it spans -4095..4095. The offset of slot s is written at address 8+s, bits [11:0]. A read with rd_en and rd_slot returns that slot's result on rd_data in the next cycle.
- R7: A stored result strictly greater than the slot's upper bound sets its high flag. A result strictly below its lower bound sets its low flag. The bounds are 13-bit signed values at addresses 16+s and 24+s. Both flags are sticky.
- R8: irq_high[s] equals high flag s AND high-enable bit s, and irq_low likewise. The enables are written at address 32 (high) and 33 (low), bit s per slot. irq_high_any and irq_low_any are the OR of each vector.
- R9: Writing ones at address 34 clears the matching high flags, and writing ones at address 35 clears the matching low flags. A flag being set in the same cycle wins over the clear.
- R10: scan_done goes to 1 in the cycle after the fourth pair is stored and returns to 0 after any read (rd_en). A set in the same cycle wins.
- R11: A sync pulse during a scan does not restart or lengthen it, and the scan still makes four requests. It sets overrun, which stays set until bit 0 is written as 1 at address 36.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 6 | Register write address |
| wr_data | input | 13 | Register write data |
| sync_in | input | 1 | Scan start pulse |
| conv_req | output | 1 | Converter pair request strobe |
| conv_ch_a | output | 3 | Channel for the first converter |
| conv_ch_b | output | 3 | Channel for the second converter |
| conv_valid | input | 1 | Converter pair data valid |
| conv_data_a | input | 12 | Code from the first converter |
| conv_data_b | input | 12 | Code from the second converter |
| rd_en | input | 1 | Result read strobe |
| rd_slot | input | 3 | Slot to read |
| rd_data | output | 13 | Signed result of the slot read |
| scan_done | output | 1 | Scan complete, cleared on read |
| overrun | output | 1 | Sticky sync-while-busy flag |
| irq_high | output | 8 | Per-slot upper-bound interrupts |
| irq_low | output | 8 | Per-slot lower-bound interrupts |
| irq_high_any | output | 1 | OR of irq_high |
| irq_low_any | output | 1 | OR of irq_low |

## Verification
The assertions assume that the converter answers each request with a single conv_valid pulse, at least one cycle after the request and before the next request. They also assume conv_valid is never raised while the block is idle. The bench's converter model watches conv_req, waits one to three cycles, and then presents both codes for one cycle, so every response lands inside the waiting phase. Register writes, reads and sync pulses are one-cycle strobes. The limit and flag checks use results at the exact bound values and at the two ends of the signed range.

// File: rtl/adcseq_pkg.sv
package adcseq_pkg;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_REQ  = 2'd1,
      ST_WAIT = 2'd2
   } seq_state_t;

   typedef enum logic [2:0] {
      RG_CHAN = 3'd0,
      RG_OFFS = 3'd1,
      RG_HIGH = 3'd2,
      RG_LOW  = 3'd3,
      RG_CTRL = 3'd4
   } reg_region_t;

   localparam int CTL_HI_EN  = 0;
   localparam int CTL_LO_EN  = 1;
   localparam int CTL_HI_CLR = 2;
   localparam int CTL_LO_CLR = 3;
   localparam int CTL_OV_CLR = 4;

endpackage

// File: rtl/adcseq_regs.sv
module adcseq_regs
   import adcseq_pkg::*;
#(
   parameter int SLOTS  = 8,
   parameter int CHAN_W = 3,
   parameter int CODE_W = 12,
   parameter logic [SLOTS*CHAN_W-1:0] DEF_MAP = '0,
   localparam int SLOT_W = $clog2(SLOTS),
   localparam int ADDR_W = SLOT_W + 3,
   localparam int RES_W  = CODE_W + 1
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         wr_en,
   input  logic [ADDR_W-1:0]            wr_addr,
   input  logic [RES_W-1:0]             wr_data,
   output logic [SLOTS-1:0][CHAN_W-1:0] chan,
   output logic [SLOTS-1:0][CODE_W-1:0] offs,
   output logic [SLOTS-1:0][RES_W-1:0]  hi_lim,
   output logic [SLOTS-1:0][RES_W-1:0]  lo_lim,
   output logic [SLOTS-1:0]             hi_en,
   output logic [SLOTS-1:0]             lo_en,
   output logic [SLOTS-1:0]             hi_clr,
   output logic [SLOTS-1:0]             lo_clr,
   output logic                         ov_clr
);

   localparam logic [RES_W-1:0] HI_RST = {1'b0, {CODE_W{1'b1}}};
   localparam logic [RES_W-1:0] LO_RST = {1'b1, {CODE_W{1'b0}}};

   logic [2:0]        region;
   logic [SLOT_W-1:0] idx;
   logic              ctl_wr;

   assign region = wr_addr[ADDR_W-1:SLOT_W];
   assign idx    = wr_addr[SLOT_W-1:0];
   assign ctl_wr = wr_en && (reg_region_t'(region) == RG_CTRL);

   assign hi_clr = (ctl_wr && idx == SLOT_W'(CTL_HI_CLR)) ? wr_data[SLOTS-1:0] : '0;
   assign lo_clr = (ctl_wr && idx == SLOT_W'(CTL_LO_CLR)) ? wr_data[SLOTS-1:0] : '0;
   assign ov_clr = ctl_wr && (idx == SLOT_W'(CTL_OV_CLR)) && wr_data[0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int s = 0; s < SLOTS; s++) begin
            chan[s]   <= DEF_MAP[s*CHAN_W +: CHAN_W];
            offs[s]   <= '0;
            hi_lim[s] <= HI_RST;
            lo_lim[s] <= LO_RST;
         end
         hi_en <= '0;
         lo_en <= '0;
      end else if (wr_en) begin
         unique case (reg_region_t'(region))
            RG_CHAN: chan[idx]   <= wr_data[CHAN_W-1:0];
            RG_OFFS: offs[idx]   <= wr_data[CODE_W-1:0];
            RG_HIGH: hi_lim[idx] <= wr_data;
            RG_LOW:  lo_lim[idx] <= wr_data;
            RG_CTRL: begin
               if (idx == SLOT_W'(CTL_HI_EN)) hi_en <= wr_data[SLOTS-1:0];
               if (idx == SLOT_W'(CTL_LO_EN)) lo_en <= wr_data[SLOTS-1:0];
            end
            default: ;
         endcase
      end
   end

endmodule

// File: rtl/adcseq_ctrl.sv
module adcseq_ctrl
   import adcseq_pkg::*;
#(
   parameter int PAIRS = 4,
   localparam int PAIR_W = $clog2(PAIRS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sync_in,
   input  logic              conv_valid,
   input  logic              rd_en,
   input  logic              ov_clr,
   output logic              conv_req,
   output logic              store,
   output logic              scan_done,
   output logic              overrun,
   output logic [PAIR_W-1:0] pair
);

   seq_state_t state_q;
   logic       last;

   assign last     = (pair == PAIR_W'(PAIRS - 1));
   assign conv_req = (state_q == ST_REQ);
   assign store    = (state_q == ST_WAIT) && conv_valid;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q   <= ST_IDLE;
         pair      <= '0;
         scan_done <= 1'b0;
         overrun   <= 1'b0;
      end else begin
         unique case (state_q)
            ST_IDLE: if (sync_in) begin
               state_q <= ST_REQ;
               pair    <= '0;
            end
            ST_REQ: state_q <= ST_WAIT;
            ST_WAIT: if (conv_valid) begin
               if (last) state_q <= ST_IDLE;
               else begin
                  state_q <= ST_REQ;
                  pair    <= pair + 1'b1;
               end
            end
            default: state_q <= ST_IDLE;
         endcase

         if (store && last) scan_done <= 1'b1;
         else if (rd_en)    scan_done <= 1'b0;

         if (sync_in && state_q != ST_IDLE) overrun <= 1'b1;
         else if (ov_clr)                   overrun <= 1'b0;
      end
   end

   // R4: one request strobe per pair
   a_r4_req_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      conv_req |=> !conv_req);

   // R2: the first pair of a scan is always preceded by a sync
   a_r2_start_on_sync: assert property (@(posedge clk) disable iff (!rst_n)
      (conv_req && pair == '0) |-> $past(sync_in));

   // R11: a sync during a scan raises the overrun flag
   a_r11_overrun_set: assert property (@(posedge clk) disable iff (!rst_n)
      (sync_in && state_q != ST_IDLE) |=> overrun);

   // R10: completion only follows a stored pair
   a_r10_done_source: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(scan_done) |-> $past(conv_valid));

endmodule

// File: rtl/adcseq_slot.sv
module adcseq_slot #(
   parameter int CODE_W = 12,
   localparam int RES_W = CODE_W + 1
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    store,
   input  logic [CODE_W-1:0]       raw,
   input  logic [CODE_W-1:0]       offs,
   input  logic signed [RES_W-1:0] hi_lim,
   input  logic signed [RES_W-1:0] lo_lim,
   input  logic                    hi_clr,
   input  logic                    lo_clr,
   output logic signed [RES_W-1:0] result,
   output logic                    hi_flag,
   output logic                    lo_flag
);

   logic signed [RES_W-1:0] diff;

   assign diff = $signed({1'b0, raw}) - $signed({1'b0, offs});

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         result  <= '0;
         hi_flag <= 1'b0;
         lo_flag <= 1'b0;
      end else begin
         if (store) result <= diff;

         if (store && diff > hi_lim) hi_flag <= 1'b1;
         else if (hi_clr)            hi_flag <= 1'b0;

         if (store && diff < lo_lim) lo_flag <= 1'b1;
         else if (lo_clr)            lo_flag <= 1'b0;
      end
   end

   // R6: the held result only changes on a store
   a_r6_result_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !store |=> $stable(result));

   // R9: flags stay set until cleared
   a_r9_hi_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (hi_flag && !hi_clr) |=> hi_flag);

   a_r9_lo_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (lo_flag && !lo_clr) |=> lo_flag);

   // R7: a flag is only raised by a stored result
   a_r7_hi_cause: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(hi_flag) |-> $past(store));

   a_r7_lo_cause: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(lo_flag) |-> $past(store));

endmodule

// File: rtl/adc_scan_seq.sv
module adc_scan_seq
   import adcseq_pkg::*;
#(
   parameter int SLOTS  = 8,
   parameter int CHAN_W = 3,
   parameter int CODE_W = 12,
   parameter logic [SLOTS*CHAN_W-1:0] DEF_MAP = 24'hD59F10,
   parameter bit READ_REG = 1'b1,
   localparam int SLOT_W = $clog2(SLOTS),
   localparam int HALF   = SLOTS / 2,
   localparam int PAIR_W = $clog2(HALF),
   localparam int ADDR_W = SLOT_W + 3,
   localparam int RES_W  = CODE_W + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [RES_W-1:0]  wr_data,
   input  logic              sync_in,
   output logic              conv_req,
   output logic [CHAN_W-1:0] conv_ch_a,
   output logic [CHAN_W-1:0] conv_ch_b,
   input  logic              conv_valid,
   input  logic [CODE_W-1:0] conv_data_a,
   input  logic [CODE_W-1:0] conv_data_b,
   input  logic              rd_en,
   input  logic [SLOT_W-1:0] rd_slot,
   output logic [RES_W-1:0]  rd_data,
   output logic              scan_done,
   output logic              overrun,
   output logic [SLOTS-1:0]  irq_high,
   output logic [SLOTS-1:0]  irq_low,
   output logic              irq_high_any,
   output logic              irq_low_any
);

   if (SLOTS < 8 || (1 << SLOT_W) != SLOTS) begin : g_bad_slots
      $fatal(1, "SLOTS must be a power of two of at least 8");
   end
   if (SLOTS > RES_W || CHAN_W > RES_W) begin : g_bad_width
      $fatal(1, "enable masks and channel fields must fit the write data");
   end

   logic [SLOTS-1:0][CHAN_W-1:0] chan;
   logic [SLOTS-1:0][CODE_W-1:0] offs;
   logic [SLOTS-1:0][RES_W-1:0]  hi_lim;
   logic [SLOTS-1:0][RES_W-1:0]  lo_lim;
   logic [SLOTS-1:0][RES_W-1:0]  result;
   logic [SLOTS-1:0]             hi_en, lo_en, hi_clr, lo_clr, hi_flag, lo_flag;
   logic                         ov_clr, store;
   logic [PAIR_W-1:0]            pair;

   adcseq_regs #(
      .SLOTS   (SLOTS),
      .CHAN_W  (CHAN_W),
      .CODE_W  (CODE_W),
      .DEF_MAP (DEF_MAP)
   ) u_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .wr_addr (wr_addr),
      .wr_data (wr_data),
      .chan    (chan),
      .offs    (offs),
      .hi_lim  (hi_lim),
      .lo_lim  (lo_lim),
      .hi_en   (hi_en),
      .lo_en   (lo_en),
      .hi_clr  (hi_clr),
      .lo_clr  (lo_clr),
      .ov_clr  (ov_clr)
   );

   adcseq_ctrl #(
      .PAIRS (HALF)
   ) u_ctrl (
      .clk        (clk),
      .rst_n      (rst_n),
      .sync_in    (sync_in),
      .conv_valid (conv_valid),
      .rd_en      (rd_en),
      .ov_clr     (ov_clr),
      .conv_req   (conv_req),
      .store      (store),
      .scan_done  (scan_done),
      .overrun    (overrun),
      .pair       (pair)
   );

   assign conv_ch_a = chan[{1'b0, pair}];
   assign conv_ch_b = chan[{1'b1, pair}];

   for (genvar s = 0; s < SLOTS; s++) begin : g_slot
      logic [CODE_W-1:0] raw;
      logic              slot_store;

      if (s < HALF) begin : g_conv_a
         assign raw = conv_data_a;
      end else begin : g_conv_b
         assign raw = conv_data_b;
      end

      assign slot_store = store && (pair == PAIR_W'(s % HALF));

      adcseq_slot #(
         .CODE_W (CODE_W)
      ) u_slot (
         .clk     (clk),
         .rst_n   (rst_n),
         .store   (slot_store),
         .raw     (raw),
         .offs    (offs[s]),
         .hi_lim  (hi_lim[s]),
         .lo_lim  (lo_lim[s]),
         .hi_clr  (hi_clr[s]),
         .lo_clr  (lo_clr[s]),
         .result  (result[s]),
         .hi_flag (hi_flag[s]),
         .lo_flag (lo_flag[s])
      );
   end

   if (READ_REG) begin : g_read_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)     rd_data <= '0;
         else if (rd_en) rd_data <= result[rd_slot];
      end
   end else begin : g_read_comb
      assign rd_data = result[rd_slot];
   end

   assign irq_high     = hi_flag & hi_en;
   assign irq_low      = lo_flag & lo_en;
   assign irq_high_any = |irq_high;
   assign irq_low_any  = |irq_low;

   // R3: channels stay put while a request is outstanding
   a_r3_chan_stable: assert property (@(posedge clk) disable iff (!rst_n)
      (conv_req && !wr_en) |=> ($stable(conv_ch_a) && $stable(conv_ch_b)));

   // R8: an interrupt bit needs a raised flag behind it
   a_r8_irq_has_flag: assert property (@(posedge clk) disable iff (!rst_n)
      ((irq_high & ~hi_flag) == '0) && ((irq_low & ~lo_flag) == '0));

endmodule

// File: tb/adc_scan_seq_bench.sv
`timescale 1ns/1ps
module adc_scan_seq_bench;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        wr_en;
   logic [5:0]  wr_addr;
   logic [12:0] wr_data;
   logic        sync_in;
   logic        conv_req;
   logic [2:0]  conv_ch_a, conv_ch_b;
   logic        conv_valid;
   logic [11:0] conv_data_a, conv_data_b;
   logic        rd_en;
   logic [2:0]  rd_slot;
   logic [12:0] rd_data;
   logic        scan_done, overrun;
   logic [7:0]  irq_high, irq_low;
   logic        irq_high_any, irq_low_any;

   always #10 clk = ~clk;

   adc_scan_seq u_adc_scan_seq (
      .clk          (clk),
      .rst_n        (rst_n),
      .wr_en        (wr_en),
      .wr_addr      (wr_addr),
      .wr_data      (wr_data),
      .sync_in      (sync_in),
      .conv_req     (conv_req),
      .conv_ch_a    (conv_ch_a),
      .conv_ch_b    (conv_ch_b),
      .conv_valid   (conv_valid),
      .conv_data_a  (conv_data_a),
      .conv_data_b  (conv_data_b),
      .rd_en        (rd_en),
      .rd_slot      (rd_slot),
      .rd_data      (rd_data),
      .scan_done    (scan_done),
      .overrun      (overrun),
      .irq_high     (irq_high),
      .irq_low      (irq_low),
      .irq_high_any (irq_high_any),
      .irq_low_any  (irq_low_any)
   );

   int n_checks = 0;
   int n_errors = 0;
   bit finished = 0;

   task automatic check(string tag, int act, int exp);
      n_checks++;
      if (act != exp) begin
         n_errors++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1;
         $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
         $finish;
      end
   endtask

   // ---------------- reference model ----------------
   int m_chan[8], m_offs[8], m_hi[8], m_lo[8], m_res[8];
   int m_hif, m_lof, m_hien, m_loen, m_state, m_pair, m_rd;
   bit m_done, m_ov, m_live;
   int def_map[8] = '{0, 2, 4, 7, 1, 3, 5, 6};

   task automatic m_reset();
      for (int s = 0; s < 8; s++) begin
         m_chan[s] = def_map[s]; m_offs[s] = 0;
         m_hi[s] = 4095; m_lo[s] = -4096; m_res[s] = 0;
      end
      m_hif = 0; m_lof = 0; m_hien = 0; m_loen = 0;
      m_state = 0; m_pair = 0; m_rd = 0; m_done = 0; m_ov = 0;
   endtask

   function automatic int to_s13(int v);
      int w;
      w = v & 8191;
      return (w >= 4096) ? w - 8192 : w;
   endfunction

   task automatic model_step();
      bit st, lastp;
      int nh, nl, sa, sb, ra, rb, wa, wd;
      st = (m_state == 2) && conv_valid;
      lastp = (m_pair == 3);
      nh = m_hif; nl = m_lof;
      sa = m_pair; sb = m_pair + 4; ra = 0; rb = 0;
      if (wr_en && wr_addr == 34) nh &= ~int'(wr_data[7:0]);
      if (wr_en && wr_addr == 35) nl &= ~int'(wr_data[7:0]);
      if (st) begin
         ra = int'(conv_data_a) - m_offs[sa];
         rb = int'(conv_data_b) - m_offs[sb];
         if (ra > m_hi[sa]) nh |= (1 << sa);
         if (rb > m_hi[sb]) nh |= (1 << sb);
         if (ra < m_lo[sa]) nl |= (1 << sa);
         if (rb < m_lo[sb]) nl |= (1 << sb);
      end
      if (rd_en) m_rd = m_res[rd_slot];
      if (st) begin m_res[sa] = ra; m_res[sb] = rb; end
      m_hif = nh; m_lof = nl;
      if (st && lastp) m_done = 1; else if (rd_en) m_done = 0;
      if (sync_in && m_state != 0) m_ov = 1;
      else if (wr_en && wr_addr == 36 && wr_data[0]) m_ov = 0;
      if (wr_en) begin
         wa = wr_addr; wd = wr_data;
         if (wa < 8)       m_chan[wa] = wd & 7;
         else if (wa < 16) m_offs[wa-8] = wd & 4095;
         else if (wa < 24) m_hi[wa-16] = to_s13(wd);
         else if (wa < 32) m_lo[wa-24] = to_s13(wd);
         else if (wa == 32) m_hien = wd & 255;
         else if (wa == 33) m_loen = wd & 255;
      end
      case (m_state)
         0: if (sync_in) begin m_state = 1; m_pair = 0; end
         1: m_state = 2;
         2: if (conv_valid) begin
               if (lastp) m_state = 0;
               else begin m_state = 1; m_pair = m_pair + 1; end
            end
         default: m_state = 0;
      endcase
   endtask

   initial begin m_reset(); m_live = 0; end

   always @(posedge clk) begin
      if (!rst_n) begin m_reset(); m_live = 0; end
      else begin model_step(); m_live = 1; end
   end

   always @(negedge clk) begin
      if (m_live) begin
         check("R4 conv_req", int'(conv_req), int'(m_state == 1));
         if (m_state == 1) begin
            check("R3 ch_a", int'(conv_ch_a), m_chan[m_pair]);
            check("R3 ch_b", int'(conv_ch_b), m_chan[m_pair+4]);
         end
         check("R10 scan_done", int'(scan_done), int'(m_done));
         check("R11 overrun", int'(overrun), int'(m_ov));
         check("R8 irq_high", int'(irq_high), m_hif & m_hien);
         check("R8 irq_low", int'(irq_low), m_lof & m_loen);
         check("R8 irq_high_any", int'(irq_high_any), int'((m_hif & m_hien) != 0));
         check("R8 irq_low_any", int'(irq_low_any), int'((m_lof & m_loen) != 0));
         check("R6 rd_data", int'($signed(rd_data)), m_rd);
      end
   end

   // ---------------- converter model and pair monitor ----------------
   int conv_val[8];
   int conv_lat = 1;
   int pq[$];

   always @(negedge clk) begin
      if (conv_req) pq.push_back(int'(conv_ch_a) * 8 + int'(conv_ch_b));
   end

   initial begin
      int ca, cb;
      conv_valid = 0; conv_data_a = '0; conv_data_b = '0;
      @(negedge clk);
      forever begin
         if (conv_req) begin
            ca = conv_ch_a; cb = conv_ch_b;
            repeat (conv_lat) @(negedge clk);
            conv_data_a = 12'(conv_val[ca]);
            conv_data_b = 12'(conv_val[cb]);
            conv_valid = 1;
            @(negedge clk);
            conv_valid = 0;
         end else begin
            @(negedge clk);
         end
      end
   end

   // ---------------- stimulus tasks (called at a falling edge) ----------------
   task automatic do_write(int a, int d);
      wr_en = 1; wr_addr = 6'(a); wr_data = 13'(d);
      @(negedge clk);
      wr_en = 0;
   endtask

   task automatic do_read(int s);
      rd_en = 1; rd_slot = 3'(s);
      @(negedge clk);
      rd_en = 0;
   endtask

   task automatic pulse_sync();
      sync_in = 1;
      @(negedge clk);
      sync_in = 0;
   endtask

   task automatic wait_done();
      while (!scan_done) @(negedge clk);
   endtask

   initial begin
      repeat (50000) @(posedge clk);
      n_errors++;
      $display("FAIL R2 watchdog actual=hung expected=scan completion");
      finish_run();
   end

   initial begin
      int map2[8];
      rst_n = 0; wr_en = 0; wr_addr = '0; wr_data = '0;
      sync_in = 0; rd_en = 0; rd_slot = '0;
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);

      // R1: reset state
      check("R1 scan_done", int'(scan_done), 0);
      check("R1 overrun", int'(overrun), 0);
      check("R1 conv_req", int'(conv_req), 0);
      check("R1 irq_high", int'(irq_high), 0);
      check("R1 irq_low", int'(irq_low), 0);

      // R2: nothing happens without sync
      for (int c = 0; c < 8; c++) conv_val[c] = 300 * c + 17;
      repeat (6) @(negedge clk);
      check("R2 no request idle", pq.size(), 0);
      pulse_sync();
      check("R2 request after sync", int'(conv_req), 1);
      wait_done();

      // R1/R3: default channel list and pair ordering
      check("R3 pair count", pq.size(), 4);
      for (int p = 0; p < 4 && p < pq.size(); p++)
         check("R1 default map pair", pq[p], def_map[p] * 8 + def_map[p+4]);

      // R6: zero offset results, R10 cleared by read
      for (int s = 0; s < 8; s++) begin
         do_read(s);
         check("R6 read slot", int'($signed(rd_data)), conv_val[def_map[s]]);
      end
      check("R10 cleared on read", int'(scan_done), 0);

      // R11: sync during a scan
      conv_lat = 3;
      pq.delete();
      pulse_sync();
      repeat (2) @(negedge clk);
      pulse_sync();
      check("R11 overrun set", int'(overrun), 1);
      wait_done();
      repeat (4) @(negedge clk);
      check("R11 scan not extended", pq.size(), 4);
      do_write(36, 1);
      check("R11 overrun cleared", int'(overrun), 0);
      do_read(0);

      // R5: new channel list, R6/R7 offsets and bounds
      conv_lat = 2;
      for (int s = 0; s < 8; s++) begin
         map2[s] = 7 - s;
         do_write(s, 7 - s);
      end
      conv_val[7] = 0;    conv_val[0] = 4095;
      conv_val[6] = 1000; conv_val[5] = 2000; conv_val[4] = 500;
      conv_val[1] = 1234; conv_val[2] = 1234; conv_val[3] = 1234;
      do_write(8, 4095);          // slot 0 offset
      do_write(16 + 1, 1000);     // slot 1 upper bound equals result
      do_write(16 + 2, 1999);     // slot 2 upper bound just below result
      do_write(24 + 0, 8192 - 4000); // slot 0 lower bound -4000
      do_write(24 + 3, 500);      // slot 3 lower bound equals result
      do_write(32, 8'h0F);
      pq.delete();
      pulse_sync();
      wait_done();
      for (int p = 0; p < 4 && p < pq.size(); p++)
         check("R5 new map pair", pq[p], map2[p] * 8 + map2[p+4]);
      check("R7 high flag strict", int'(irq_high), 8'h04);
      check("R8 low masked", int'(irq_low), 0);
      do_write(33, 8'hFF);
      check("R8 low enabled", int'(irq_low), 8'h01);
      check("R8 any high", int'(irq_high_any), 1);
      do_read(0);
      check("R6 most negative", int'($signed(rd_data)), -4095);
      do_read(7);
      check("R6 most positive", int'($signed(rd_data)), 4095);
      do_read(2);
      check("R6 slot2", int'($signed(rd_data)), 2000);

      // R9: clears
      do_write(34, 8'h04);
      check("R9 high cleared", int'(irq_high), 0);
      do_write(35, 8'h01);
      check("R9 low cleared", int'(irq_low), 0);

      // R7 sticky across another scan with results inside bounds
      conv_val[5] = 1500; conv_val[7] = 4000;
      do_write(34, 0);
      pulse_sync();
      wait_done();
      check("R7 no new high", int'(irq_high), 0);
      check("R7 no new low", int'(irq_low), 0);
      do_read(0);
      check("R6 slot0 second", int'($signed(rd_data)), 4000 - 4095);

      repeat (4) @(negedge clk);
      finish_run();
   end

endmodule